// File: doc/BRIEF.md
# Shared Prescaler Timer and Watchdog Divider

This block holds an 8-bit timer/counter and a watchdog time-out path that share a single programmable power-of-two divider. An option byte steers the divider. It can sit in front of the timer, where it divides the timer's clock events. It can also sit behind the incoming watchdog tick, where it acts as a postscaler. The side that does not hold the divider runs at 1:1. The timer clocks from an internal instruction-cycle tick, which is one event every four core clocks. It can instead count edges on an external pin, on either the rising or the falling edge.

Software writes the option byte and reads or writes the timer through plain strobed ports. When the timer wraps, a sticky overflow flag is raised and stays up until software clears it. Each time the watchdog path completes a division period, it produces a one-cycle time-out pulse. Any event that starts a new count resets the shared divider to zero. These events are a timer write, a change of divider assignment, and a watchdog clear while the divider sits on the watchdog side.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the option byte reads FFh, the timer reads 00h, and the overflow flag and time-out pulse are low.
- R2: With option bit 6 at 0, the timer clock is the internal instruction tick, one event in every 4 core clock cycles, and the pin is ignored.
- R3: With option bit 3 at 0, the divider feeds the timer. The timer then advances once per 2^(rate+1) clock events, where rate is option bits [2:0] (000 gives 1:2, 111 gives 1:256).
- R4: With option bit 3 at 1, the timer advances on every clock event (1:1).
- R5: With option bit 6 at 1, the timer counts edges of the external pin after a two-flop synchroniser. Option bit 7 at 0 selects rising edges and at 1 selects falling edges. The opposite edge is not counted.
- R6: A timer write loads the value on the next clock edge, takes priority over any increment that cycle, and clears the divider count.
- R7: When the timer wraps from FFh to 00h, a sticky overflow flag is set. The flag stays set until ovf_clr is pulsed. A set in the same cycle wins over the clear.
- R8: With option bit 3 at 0, every watchdog tick produces a time-out pulse on the next cycle. With option bit 3 at 1, a pulse follows every 2^rate-th tick.
- R9: A watchdog clear while option bit 3 is 1 restarts the divider count. A write that changes option bit 3 also restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Option byte write strobe |
| opt_wdata | input | 8 | Option byte write data |
| opt_q | output | 8 | Current option byte |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_q | output | 8 | Current timer value |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog base tick, one cycle per tick |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_timeout | output | 1 | Watchdog time-out pulse |

## Verification
The bench builds the block with its default parameters: a four-cycle instruction tick, a two-stage pin synchroniser, and an 8-bit timer with a three-bit rate field. These values make the full ratio range reachable, including the 1:256 end. The timer side of that end takes 1024 core cycles per count, which is short enough to test on both sides of the boundary. The windows are counted in whole multiples of four cycles after a timer write clears the divider. Every expected timer value is therefore exact, whatever the phase of the instruction tick.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int unsigned OPT_W  = 8;
  localparam int unsigned RATE_W = 3;

  // Option byte layout; bit 3 position is fixed, the rest chosen for this block
  typedef struct packed {
    logic              edge_fall;   // [7] 1: count falling pin edges
    logic              src_ext;     // [6] 1: external pin, 0: instruction tick
    logic [1:0]        spare;       // [5:4] stored, no effect
    logic              div_to_wdt;  // [3] 1: divider behind watchdog
    logic [RATE_W-1:0] rate;        // [2:0] ratio exponent
  } sdt_opt_t;
endpackage

// File: rtl/sdt_cycle_tick.sv
module sdt_cycle_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cyc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (DIV == 1));
endmodule

// File: rtl/sdt_edge_sync.sv
module sdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

  // R5
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(pin, STAGES));
  // R5
  fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> !$past(pin, STAGES));
endmodule

// File: rtl/sdt_divider.sv
module sdt_divider #(
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_evt,
  input  logic [RATE_W:0]   shift,
  output logic              pulse
);
  localparam int unsigned DW = 1 << RATE_W;

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW:0]   lim_w;
  logic [DW-1:0] lim;

  always_comb begin
    lim_w = ({{DW{1'b0}}, 1'b1} << shift) - 1'b1;
    lim   = lim_w[DW-1:0];
  end

  assign pulse = in_evt && !clr && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (in_evt)  cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  div_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_evt) |=> $stable(cnt_q));
endmodule

// File: rtl/sdt_timer.sv
module sdt_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic [W-1:0] cnt_d;
  logic         ovf_d;
  logic         wrap;

  assign wrap = inc && !we && (cnt == {W{1'b1}});

  always_comb begin
    cnt_d = cnt;
    if (we)       cnt_d = wdata;
    else if (inc) cnt_d = cnt + 1'b1;
    ovf_d = ovf;
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_d;
      ovf <= ovf_d;
    end
  end

  // R6
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cnt == $past(wdata));
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !we && cnt == {W{1'b1}}) |=> (ovf && cnt == '0));
  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer #(
  parameter int unsigned CYC_DIV     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opt_we,
  input  logic [7:0] opt_wdata,
  output logic [7:0] opt_q,
  input  logic       tmr_we,
  input  logic [7:0] tmr_wdata,
  output logic [7:0] tmr_q,
  input  logic       ovf_clr,
  output logic       ovf_flag,
  input  logic       ext_clk_in,
  input  logic       wdt_tick,
  input  logic       wdt_clr,
  output logic       wdt_timeout
);
  import sdt_pkg::*;

  sdt_opt_t opt_r, opt_d, opt_new;
  logic     cyc_tick, pin_rise, pin_fall;
  logic     tmr_evt, div_in, div_pulse, div_clr, tmr_inc, assign_chg;
  logic     to_d;
  logic [RATE_W:0] shift;

  assign opt_new = sdt_opt_t'(opt_wdata);

  always_comb begin
    opt_d = opt_we ? opt_new : opt_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_r <= sdt_opt_t'({OPT_W{1'b1}});
    else        opt_r <= opt_d;
  end

  assign opt_q = opt_r;

  sdt_cycle_tick #(.DIV(CYC_DIV)) u_cyc (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick));

  sdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk_in),
    .rise(pin_rise), .fall(pin_fall));

  always_comb begin
    if (opt_r.src_ext) tmr_evt = opt_r.edge_fall ? pin_fall : pin_rise;
    else               tmr_evt = cyc_tick;
    assign_chg = opt_we && (opt_new.div_to_wdt != opt_r.div_to_wdt);
    div_clr    = tmr_we || assign_chg || (wdt_clr && opt_r.div_to_wdt);
    div_in     = opt_r.div_to_wdt ? wdt_tick : tmr_evt;
    shift      = opt_r.div_to_wdt ? {1'b0, opt_r.rate}
                                  : {1'b0, opt_r.rate} + 1'b1;
    tmr_inc    = opt_r.div_to_wdt ? tmr_evt : div_pulse;
    to_d       = opt_r.div_to_wdt ? div_pulse : wdt_tick;
  end

  sdt_divider #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .in_evt(div_in),
    .shift(shift), .pulse(div_pulse));

  sdt_timer #(.W(8)) u_tmr (
    .clk(clk), .rst_n(rst_n), .inc(tmr_inc), .we(tmr_we),
    .wdata(tmr_wdata), .ovf_clr(ovf_clr), .cnt(tmr_q), .ovf(ovf_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_timeout <= 1'b0;
    else        wdt_timeout <= to_d;
  end

  // R8
  wdt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> $past(wdt_tick));
  // R8
  wdt_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_r.div_to_wdt && wdt_tick) |=> wdt_timeout);
  // R4
  tmr_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_r.div_to_wdt && !opt_r.src_ext && cyc_tick && !tmr_we)
      |=> tmr_q == $past(tmr_q) + 8'd1);
endmodule

// File: tb/shared_prescale_timer_tb.sv
`timescale 1ns/1ps
module shared_prescale_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opt_we = 1'b0;
  logic [7:0] opt_wdata = '0;
  logic [7:0] opt_q;
  logic       tmr_we = 1'b0;
  logic [7:0] tmr_wdata = '0;
  logic [7:0] tmr_q;
  logic       ovf_clr = 1'b0;
  logic       ovf_flag;
  logic       ext_clk_in = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       wdt_clr = 1'b0;
  logic       wdt_timeout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;   // 0 timer, 1 overflow, 2 timeout, 3 option
    int    exp;
    string req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  shared_prescale_timer u_dut (
    .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
    .opt_q(opt_q), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .ext_clk_in(ext_clk_in),
    .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout));

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(int kind, int exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        case (it.kind)
          0: act = int'(tmr_q);
          1: act = int'(ovf_flag);
          2: act = int'(wdt_timeout);
          default: act = int'(opt_q);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s kind %0d: actual %0h expected %0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic set_opt(logic [7:0] v);
    opt_we = 1'b1; opt_wdata = v; cyc(1); opt_we = 1'b0;
  endtask

  task automatic set_tmr(logic [7:0] v);
    tmr_we = 1'b1; tmr_wdata = v; cyc(1); tmr_we = 1'b0;
  endtask

  task automatic pin_pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b1; cyc(3);
      ext_clk_in = 1'b0; cyc(3);
    end
    cyc(4);
  endtask

  task automatic tick_wdt(int exp, string req);
    wdt_tick = 1'b1; cyc(1);
    expect_item(2, exp, req);
    wdt_tick = 1'b0; cyc(1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    expect_item(3, 8'hFF, "R1");
    expect_item(0, 8'h00, "R1");
    expect_item(1, 0, "R1");
    expect_item(2, 0, "R1");
    cyc(1);

    // R2 R3 internal tick, divider on timer, 1:2
    set_opt(8'h00);
    set_tmr(8'h10);
    expect_item(0, 8'h10, "R6");
    cyc(40);
    expect_item(0, 8'h15, "R3");
    ext_clk_in = 1'b1; cyc(3); ext_clk_in = 1'b0; cyc(5);
    expect_item(0, 8'h16, "R2");   // pin ignored: 48 cycles -> 6 counts

    // R3 rate 2 -> 1:8
    set_opt(8'h02);
    set_tmr(8'h00);
    cyc(96);
    expect_item(0, 8'h03, "R3");

    // R3 rate 7 -> 1:256 boundary
    set_opt(8'h07);
    set_tmr(8'h40);
    cyc(1020);
    expect_item(0, 8'h40, "R3");
    cyc(4);
    expect_item(0, 8'h41, "R3");

    // R4 divider on watchdog: timer 1:1
    set_opt(8'h0A);
    set_tmr(8'h20);
    cyc(28);
    expect_item(0, 8'h27, "R4");

    // R7 wrap and sticky flag
    set_opt(8'h08);
    set_tmr(8'hFE);
    cyc(4);
    expect_item(1, 0, "R7");
    cyc(4);
    expect_item(0, 8'h00, "R7");
    expect_item(1, 1, "R7");
    cyc(8);
    expect_item(0, 8'h02, "R7");
    expect_item(1, 1, "R7");
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    expect_item(1, 0, "R7");

    // R5 external rising, 1:1
    set_opt(8'h48);
    set_tmr(8'h00);
    pin_pulses(5);
    expect_item(0, 8'h05, "R5");

    // R5 external falling: rise alone not counted
    set_opt(8'hC8);
    set_tmr(8'h00);
    ext_clk_in = 1'b1; cyc(6);
    expect_item(0, 8'h00, "R5");
    ext_clk_in = 1'b0; cyc(6);
    expect_item(0, 8'h01, "R5");

    // R5 R3 external rising through divider 1:2
    set_opt(8'h40);
    set_tmr(8'h00);
    pin_pulses(4);
    expect_item(0, 8'h02, "R5");

    // R8 divider on timer: every tick times out
    set_opt(8'h00);
    tick_wdt(1, "R8");
    expect_item(2, 0, "R8");
    tick_wdt(1, "R8");

    // R9 assignment change clears partial divider count
    set_opt(8'h02);
    set_tmr(8'h00);
    cyc(12);
    set_opt(8'h0A);
    for (int i = 0; i < 3; i++) tick_wdt(0, "R9");
    tick_wdt(1, "R8");
    for (int i = 0; i < 3; i++) tick_wdt(0, "R8");
    wdt_clr = 1'b1; cyc(1); wdt_clr = 1'b0;
    for (int i = 0; i < 3; i++) tick_wdt(0, "R9");
    tick_wdt(1, "R9");

    // R8 watchdog ratio 1:1 at rate 0
    set_opt(8'h08);
    tick_wdt(1, "R8");
    tick_wdt(1, "R8");

    cyc(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule